// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and a 64K-word by 16-bit asynchronous static RAM. A client offers one access at a time with a valid/ready handshake: a read or write flag, a word address, write data and a two-bit lane mask. The sequencer then drives the memory pins through a fixed pattern of clock cycles. Chip select is active high. Output enable, write strobe and the two lane selects are active low. When the access ends, the sequencer returns a one-cycle completion pulse, and for reads it also returns registered read data.

All cycle counts come from nanosecond limits and the clock period, each rounded up to whole ticks. The ns limits cover the read cycle and access times, the write pulse width, address-to-strobe-end setup, data setup and the memory's output release time. At the default 10 ns clock:
- A read holds output enable low for 12 cycles.
- A write holds the strobe low for 10 cycles and is followed by 2 recovery cycles.
- Write data is driven only during the last 5 strobe cycles.
- After a read, 4 quiet cycles follow before any new access is taken, so the memory can release the data bus.

The data bus is split into an output value, an output-enable and an input value, so the pad tristate can be built outside this block. The sequencer itself never drives the bus while the memory may still be driving it.

Top module: `asram_seq`

## Requirements
- R1: While reset is held, and after its release, the outputs are idle: req_ready=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_be_n=2'b11, mem_dq_oe=0, done=0.
- R2: A read with a non-zero mask keeps mem_cs=1 and mem_oe_n=0 for exactly 12 consecutive cycles, with mem_we_n=1 throughout. done rises 13 cycles after the accepting clock edge.
- R3: At a read's done, rdata holds mem_dq_i as sampled in the last output-enable cycle for each enabled lane (bits 7:0 = lane 0, bits 15:8 = lane 1), and zero for each disabled lane. rdata keeps that value until the next read completes; writes leave it unchanged.
- R4: Mask bit 0 selects lane 0 (mem_be_n[0]) and mask bit 1 selects lane 1 (mem_be_n[1]). A lane select is low only while mem_cs=1 and its mask bit is set; otherwise it is high.
- R5: A write with a non-zero mask holds mem_we_n=0 for exactly 10 consecutive cycles with mem_cs=1 throughout. mem_addr does not change while the strobe is low. done rises 11 cycles after acceptance.
- R6: mem_dq_oe=1 only during the last 5 cycles of a write strobe, with mem_dq_o equal to the request's write data. mem_dq_oe and mem_we_n change at the same clock edge at the end of the strobe.
- R7: mem_dq_oe is never 1 while mem_oe_n=0, nor within the 4 cycles after mem_oe_n returns high.
- R8: req_ready returns high 17 cycles after accepting a read, 13 cycles after a write and 2 cycles after an empty-mask request.
- R9: A request with mask 2'b00 touches no memory pin (mem_cs, mem_we_n and mem_oe_n stay inactive). Its done comes 1 cycle after acceptance. An empty read returns rdata=0, and an empty write leaves memory contents unchanged.
- R10: Only one access is in flight: req_ready is low from acceptance until the sequence ends, and mem_cs=1 never coincides with req_ready=1. done is a single-cycle pulse, given once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Registered read data |
| mem_addr | output | 16 | Memory address pins |
| mem_cs | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane selects, active low |
| mem_dq_o | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Enable for the bus drivers |
| mem_dq_i | input | 16 | Data read from the bus |

## Verification
The bench mixes seeded random traffic with directed cases that attack each part of the sequence.

- **Write right after a read.** A design with too short a quiet gap would turn on its bus drivers while the memory might still be driving.
- **Single-lane accesses.** Writing one lane and reading back both lanes catches a swapped or ignored mask, which would corrupt or leak the neighbouring byte.
- **Empty-mask requests.** These catch a design that still pulses the strobe or output enable, or that leaves stale read data.
- **Strobe and driver windows.** Strobe length and driver-window length are counted at the pins, so an off-by-one in any counter shows up as a wrong width or a wrong done or ready latency.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_NOP    = 3'd1,
    ST_RD_ACT = 3'd2,
    ST_RD_REL = 3'd3,
    ST_WR_LOW = 3'd4,
    ST_WR_REC = 3'd5
  } st_e;

  function automatic int ticks(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC = 12,
  parameter int WE_CYC = 10,
  parameter int WREC   = 2,
  parameter int TURN   = 4,
  parameter int LANES  = 2,
  parameter int CW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_bmask,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_end,
  output logic             done,
  output st_e              st_d,
  output logic [CW-1:0]    cnt_d
);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          done_d;
  logic          cnt_en;
  logic          cnt_zero;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cnt_zero  = (cnt_q == '0);
  assign rd_end    = (st_q == ST_RD_ACT) && cnt_zero;
  assign cnt_en    = (st_q != ST_IDLE) || accept;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_zero ? '0 : cnt_q - CW'(1);
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_bmask == '0) begin
            st_d   = ST_NOP;
            done_d = 1'b1;
          end else if (req_write) begin
            st_d  = ST_WR_LOW;
            cnt_d = CW'(WE_CYC - 1);
          end else begin
            st_d  = ST_RD_ACT;
            cnt_d = CW'(RD_CYC - 1);
          end
        end
      end
      ST_NOP: st_d = ST_IDLE;
      ST_RD_ACT: begin
        if (cnt_zero) begin
          st_d   = ST_RD_REL;
          cnt_d  = CW'(TURN - 1);
          done_d = 1'b1;
        end
      end
      ST_RD_REL: if (cnt_zero) st_d = ST_IDLE;
      ST_WR_LOW: begin
        if (cnt_zero) begin
          st_d   = ST_WR_REC;
          cnt_d  = CW'(WREC - 1);
          done_d = 1'b1;
        end
      end
      ST_WR_REC: if (cnt_zero) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R10

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_bmask,
  input  logic             rd_end,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    addr_d,
  output logic [DW-1:0]    wdata_d,
  output logic [LANES-1:0] mask_d,
  output logic [DW-1:0]    rdata
);

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    rdata_d;
  logic             rd_cap;

  assign addr_d  = accept ? req_addr  : addr_q;
  assign wdata_d = accept ? req_wdata : wdata_q;
  assign mask_d  = accept ? req_bmask : mask_q;

  // Empty-mask reads load zero through the same path as real reads.
  assign rd_cap = rd_end || (accept && !req_write && (req_bmask == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rdata_d[8*i +: 8] = (rd_end && mask_q[i]) ? mem_dq_i[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        mask_q  <= mask_d;
      end
      if (rd_cap) rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LANES  = 2,
  parameter int CW     = 4,
  parameter int DS_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  st_e              st_d,
  input  logic [CW-1:0]    cnt_d,
  input  logic [AW-1:0]    addr_d,
  input  logic [DW-1:0]    wdata_d,
  input  logic [LANES-1:0] mask_d,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_be_n,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe
);

  logic             act_n;
  logic             we_nn;
  logic             oe_nn;
  logic             dqoe_n;
  logic [LANES-1:0] be_nn;

  // Pins are decoded from next-state values and registered: glitch-free strobes.
  assign act_n  = (st_d == ST_RD_ACT) || (st_d == ST_WR_LOW);
  assign we_nn  = (st_d != ST_WR_LOW);
  assign oe_nn  = (st_d != ST_RD_ACT);
  assign dqoe_n = (st_d == ST_WR_LOW) && (cnt_d < CW'(DS_CYC));

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be_nn[i] = !(act_n && mask_d[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_cs    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs    <= act_n;
      mem_we_n  <= we_nn;
      mem_oe_n  <= oe_nn;
      mem_be_n  <= be_nn;
      mem_dq_oe <= dqoe_n;
      if (act_n)  mem_addr <= addr_d;
      if (dqoe_n) mem_dq_o <= wdata_d;
    end
  end

  AST_NO_WE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R2

  AST_DQ_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_cs)); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R5

  AST_DQ_OFF_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe); // R6

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CLK_NS      = 10,
  parameter int T_RC_NS     = 120,
  parameter int T_ACC_NS    = 120,
  parameter int T_OEACC_NS  = 60,
  parameter int T_WC_NS     = 120,
  parameter int T_WP_NS     = 85,
  parameter int T_AW_NS     = 100,
  parameter int T_DS_NS     = 45,
  parameter int T_REL_NS    = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_bmask,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_cs,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i
);

  localparam int LANES  = DW / 8;
  localparam int RD_CYC = max2(max2(ticks(T_RC_NS, CLK_NS), ticks(T_ACC_NS, CLK_NS)),
                               ticks(T_OEACC_NS, CLK_NS));
  localparam int WE_CYC = max2(ticks(T_WP_NS, CLK_NS), ticks(T_AW_NS, CLK_NS));
  localparam int DS_CYC = max2(ticks(T_DS_NS, CLK_NS), 1);
  localparam int WR_TOT = max2(ticks(T_WC_NS, CLK_NS), WE_CYC + 1);
  localparam int WREC   = WR_TOT - WE_CYC;
  localparam int TURN   = max2(ticks(T_REL_NS, CLK_NS), 1);
  localparam int CW     = $clog2(max2(max2(RD_CYC, WE_CYC), max2(TURN, WREC)) + 2);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  st_e              st_d;
  logic [CW-1:0]    cnt_d;
  logic             accept;
  logic             rd_end;
  logic [AW-1:0]    addr_d;
  logic [DW-1:0]    wdata_d;
  logic [LANES-1:0] mask_d;

  asram_fsm #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .WREC(WREC), .TURN(TURN),
    .LANES(LANES), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_ni), .req_valid(req_valid), .req_write(req_write),
    .req_bmask(req_bmask), .req_ready(req_ready), .accept(accept),
    .rd_end(rd_end), .done(done), .st_d(st_d), .cnt_d(cnt_d)
  );

  asram_dpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dpath (
    .clk(clk), .rst_n(rst_ni), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rd_end(rd_end), .mem_dq_i(mem_dq_i), .addr_d(addr_d),
    .wdata_d(wdata_d), .mask_d(mask_d), .rdata(rdata)
  );

  asram_pins #(
    .AW(AW), .DW(DW), .LANES(LANES), .CW(CW), .DS_CYC(DS_CYC)
  ) u_pins (
    .clk(clk), .rst_n(rst_ni), .st_d(st_d), .cnt_d(cnt_d), .addr_d(addr_d),
    .wdata_d(wdata_d), .mask_d(mask_d), .mem_addr(mem_addr), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  // Window counters for the timing assertions below.
  logic [CW-1:0] oe_gap;
  logic [CW-1:0] we_len;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_gap <= CW'(TURN);
      we_len <= '0;
    end else begin
      if (!mem_oe_n)               oe_gap <= '0;
      else if (oe_gap < CW'(TURN)) oe_gap <= oe_gap + CW'(1);
      if (!mem_we_n) we_len <= we_len + CW'(1);
      else           we_len <= '0;
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_dq_oe |-> (mem_oe_n && (oe_gap >= CW'(TURN)))); // R7

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_we_n) |-> (we_len == CW'(WE_CYC))); // R5

  AST_CS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_cs |-> !req_ready); // R10

  AST_LANE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_cs |-> (mem_be_n == '1)); // R4

endmodule

// File: tb/tb_asram_seq.sv
module tb_asram_seq;

  localparam int RD  = 12;
  localparam int WE  = 10;
  localparam int DS  = 5;
  localparam int REC = 2;
  localparam int TRN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, done;
  logic [15:0] rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  always #2 clk = ~clk;

  asram_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int nchk = 0;
  int nfail = 0;

  logic [15:0] model   [0:255];
  logic [15:0] ref_mem [0:255];

  // Memory model: drives lanes only while selected and reading.
  always_comb begin
    for (int i = 0; i < 2; i++)
      mem_dq_i[8*i +: 8] = (mem_cs && !mem_oe_n && !mem_be_n[i])
                           ? model[mem_addr[7:0]][8*i +: 8] : 8'hA5;
  end

  // Pin monitor state, cleared per access.
  int          cs_cyc, oe_cyc, we_cnt, dq_cnt, we_last, dq_last, gap;
  bit          be_bad, contend, dbad, abad;
  logic [1:0]  exp_mask;
  logic [15:0] exp_wd, last_dq, prev_addr;
  logic [1:0]  last_be;
  logic        prev_we_n = 1'b1;

  initial gap = 100;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_cs) cs_cyc++;
      if (!mem_oe_n) oe_cyc++;
      if (mem_cs && (~mem_be_n != exp_mask)) be_bad = 1;
      if (!mem_cs && (mem_be_n != 2'b11)) be_bad = 1;
      if (mem_dq_oe && (!mem_oe_n || gap < TRN)) contend = 1;
      if (!mem_oe_n) gap = 0; else if (gap < 100) gap++;
      if (mem_dq_oe && mem_we_n) dbad = 1;
      if (!mem_we_n) begin
        we_cnt++;
        last_be = mem_be_n;
        if (mem_dq_oe) begin
          dq_cnt++;
          last_dq = mem_dq_o;
          if (mem_dq_o != exp_wd) dbad = 1;
        end
        if (!prev_we_n && mem_addr != prev_addr) abad = 1;
      end else if (!prev_we_n) begin
        for (int i = 0; i < 2; i++)
          if (!last_be[i]) model[prev_addr[7:0]][8*i +: 8] = last_dq[8*i +: 8];
        we_last = we_cnt;
        dq_last = dq_cnt;
        we_cnt = 0;
        dq_cnt = 0;
      end
      prev_we_n = mem_we_n;
      prev_addr = mem_addr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] m);
    logic [15:0] v;
    v[7:0]  = m[0] ? ref_mem[a[7:0]][7:0]  : 8'h00;
    v[15:8] = m[1] ? ref_mem[a[7:0]][15:8] : 8'h00;
    return v;
  endfunction

  function automatic int exp_done_lat(input bit w, input logic [1:0] m);
    if (m == 2'b00) return 1;
    return w ? WE + 1 : RD + 1;
  endfunction

  function automatic int exp_ready_lat(input bit w, input logic [1:0] m);
    if (m == 2'b00) return 2;
    return w ? WE + REC + 1 : RD + TRN + 1;
  endfunction

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    int kd = 0;
    int kr = 0;
    int nd = 0;
    logic [15:0] rd_before;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_before = rdata;
    cs_cyc = 0; oe_cyc = 0; we_last = 0; dq_last = 0;
    be_bad = 0; contend = 0; dbad = 0; abad = 0;
    exp_mask = m; exp_wd = d;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_bmask = m;
    @(posedge clk);
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (done) begin
        nd++;
        if (kd == 0) kd = k;
      end
      if (req_ready) begin
        kr = k;
        break;
      end
    end
    check(kd == exp_done_lat(w, m), w ? "R5 done latency" : "R2 done latency",
          kd, exp_done_lat(w, m));
    check(kr == exp_ready_lat(w, m), "R8 ready latency", kr, exp_ready_lat(w, m));
    check(nd == 1, "R10 single done", nd, 1);
    check(!be_bad, "R4 lane selects", be_bad, 0);
    check(!contend, "R7 bus turnaround", contend, 0);
    if (m == 2'b00) begin
      check(cs_cyc == 0 && oe_cyc == 0 && we_last == 0, "R9 pins quiet",
            cs_cyc + oe_cyc + we_last, 0);
      if (!w) check(rdata == 16'h0000, "R9 empty read data", rdata, 0);
    end else if (w) begin
      check(we_last == WE && cs_cyc == WE, "R5 strobe width", we_last, WE);
      check(!abad, "R5 address stable", abad, 0);
      check(dq_last == DS && !dbad, "R6 data window", dq_last, DS);
      check(rdata == rd_before, "R3 rdata held over write", rdata, rd_before);
    end else begin
      check(oe_cyc == RD && cs_cyc == RD, "R2 output enable width", oe_cyc, RD);
      check(rdata == exp_read(a, m), "R3 read data", rdata, exp_read(a, m));
    end
    if (w) begin
      if (m[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
      if (m[1]) ref_mem[a[7:0]][15:8] = d[15:8];
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i] = 16'h0000;
      ref_mem[i] = 16'h0000;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(req_ready && !mem_cs && mem_we_n && mem_oe_n && mem_be_n == 2'b11 &&
          !mem_dq_oe && !done, "R1 reset pins",
          {req_ready, mem_cs, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, done}, 8'hBC);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 after release",
          {req_ready, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

    // Directed corners
    access(1, 16'h0010, 16'hBEEF, 2'b11);
    access(0, 16'h0010, 16'h0000, 2'b11);   // R3 full word
    access(1, 16'h0010, 16'h1234, 2'b01);   // R4 low lane only
    access(0, 16'h0010, 16'h0000, 2'b11);
    access(1, 16'h0010, 16'h5678, 2'b10);   // R4 high lane only
    access(0, 16'h0010, 16'h0000, 2'b01);   // R3 disabled lane zero
    access(0, 16'h0010, 16'h0000, 2'b10);
    access(1, 16'h0010, 16'hFFFF, 2'b00);   // R9 empty write
    access(0, 16'h0010, 16'h0000, 2'b11);   // R9 content unchanged
    access(0, 16'h0010, 16'h0000, 2'b00);   // R9 empty read
    access(0, 16'h0020, 16'h0000, 2'b11);   // read after read
    access(1, 16'h0020, 16'hA55A, 2'b11);   // R7 write right after read
    access(1, 16'hFF21, 16'h0F0F, 2'b11);   // write after write
    access(0, 16'hFF21, 16'h0000, 2'b11);

    // Seeded random traffic
    for (int n = 0; n < 80; n++) begin
      bit          w = 1'($urandom() & 1);
      logic [15:0] a = {8'($urandom()), 4'h0, 4'($urandom())};
      logic [15:0] d = 16'($urandom());
      logic [1:0]  m = 2'($urandom());
      access(w, a, d, m);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule